// File: doc/BRIEF.md
# Motor Protection Supervisor

This block watches the run state of a three-phase bridge controller together with its fault flags and decides when the gate drivers must be disabled. It produces two commands. `lo_off` disables the lower-side switches. `all_off` disables every switch in the bridge. Four protections feed those commands:

- An initial hold after power-up.
- An under-voltage hold.
- A thermal hold.
- A speed-supervision pair:
  - a stall detector, which latches;
  - a missing-clock detector, which releases by itself.

All timing is counted in pulses of a slow timebase input (`tick`), so the windows scale with that pulse rate rather than with the core clock. The clock-loss window is fixed at one thirty-fourth of the stall window, rounded down.

Every asynchronous input passes through a two-stage synchroniser before it is used. The block is in the "driving" state when neither stop nor brake is requested. The stall, clock-loss and thermal protections act only in that state. A latched stall is cleared only when the motor leaves the driving state for a qualified interval and then returns to it.

Top module: `motor_prot_sup`

## Requirements
- R1: From reset, and until INIT_TICKS ticks have been counted after reset is released, both `all_off` and `lo_off` are 1.
- R2: While the synchronised `uv_flt` is 1, `all_off` and `lo_off` are 1. They return to 0 when the flag clears, provided no other condition holds them.
- R3: In the driving state (`stop_sel`=0 and `brake_sel`=0), a synchronised `therm_flt`=1 drives `lo_off` to 1 and leaves `all_off` at 0. `lo_off` releases when the flag clears.
- R4: When `stop_sel`=1 or `brake_sel`=1, the thermal flag and a missing command clock have no effect on `lo_off`.
- R5: In the driving state, `lock_det`=0 (1 means speed locked) held for STALL_TICKS ticks sets a stall latch that forces `lo_off`=1. The latch stays set after `lock_det` returns to 1.
- R6: If no rising edge arrives on `cmd_clk` for STALL_TICKS/34 ticks (rounded down), `lo_off` is 1 in the driving state. It releases by itself once edges resume.
- R7: The stall count is held at zero while clock loss, thermal or under-voltage protection is active. No stall latch forms during those conditions, however long lock is absent.
- R8: A stall latch clears only when the block leaves the driving state (stop or brake) for at least REARM_TICKS ticks and then re-enters it. A shorter excursion leaves the latch set.
- R9: The timers advance only on cycles where `tick`=1. With `tick` held at 0, absent lock never produces a stall.
- R10: Each asynchronous input takes effect on the outputs two clock edges after it changes. For example, a thermal flag asserted before edge k shows on `lo_off` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick | input | 1 | Timebase pulse, one core-clock cycle wide, synchronous |
| lock_det | input | 1 | Speed-lock indication, 1 = locked (async) |
| cmd_clk | input | 1 | Speed command clock (async) |
| stop_sel | input | 1 | 1 = stop requested (async) |
| brake_sel | input | 1 | 1 = brake requested (async) |
| therm_flt | input | 1 | Over-temperature flag, hysteresis applied outside (async) |
| uv_flt | input | 1 | Supply under-voltage flag (async) |
| lo_off | output | 1 | Disable lower-side gate drives |
| all_off | output | 1 | Disable all gate drives |

## Verification
Fault flags reach the outputs exactly two edges after they change, through the synchroniser. With `tick` high every cycle, the stall latch forms STALL_TICKS+3 edges after `lock_det` falls, and the initial hold ends INIT_TICKS edges after reset release. The bench pushes each expectation into the scoreboard only after waiting that exact number of rising edges from a falling-edge stimulus. It then compares at the next falling edge, and brackets the stall instant and the reset end one edge either side. The clock-loss and re-arm windows depend on the phase of the command clock or on the clear edge, so their checks sample at points well clear of either boundary.

// File: rtl/mps_pkg.sv
// Package: shared constants and the bundle of asynchronous inputs that
// the protection supervisor synchronises before use.
package mps_pkg;
    // Ratio between the stall window and the clock-loss window.
    localparam int CLK_LOSS_DIV = 34;

    // Asynchronous inputs, synchronised together as one vector.
    typedef struct packed {
        logic lock;
        logic cmd;
        logic stop;
        logic brake;
        logic therm;
        logic uv;
    } prot_in_t;
endpackage

// File: rtl/mps_sync.sv
// Module: multi-bit flop-chain synchroniser.
// Each bit is sampled independently through STAGES flops. The bits are
// assumed to be unrelated levels, so no coherency between bits is claimed.
// STAGES must be at least 2.
module mps_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mps_tick_timer.sv
// Module: saturating timebase counter.
// The count advances by one on each cycle where tick and run are both 1.
// It is cleared by clr, which has priority, and it stops at LIMIT.
// done is 1 while the count equals LIMIT.
module mps_tick_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic clr,
    output logic done
);
    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt >= CW'(LIMIT));

    // Count qualified ticks up to LIMIT; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (clr)                   cnt <= '0;
        else if (tick && run && !done)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/motor_prot_sup.sv
// Module: protection supervisor for a three-phase bridge pre-driver.
//
// What it does:
//   - combines the power-up hold, under-voltage, thermal, clock-loss and
//     stall protections into a lower-side disable and an all-off request;
//   - latches the stall fault, and re-arms it only after a qualified
//     period outside the driving state.
//
// What it assumes:
//   - tick is synchronous to clk and one cycle wide;
//   - every other input is asynchronous and is synchronised here.
module motor_prot_sup
    import mps_pkg::*;
#(
    parameter int STALL_TICKS = 340,
    parameter int INIT_TICKS  = 8,
    parameter int REARM_TICKS = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lock_det,
    input  logic cmd_clk,
    input  logic stop_sel,
    input  logic brake_sel,
    input  logic therm_flt,
    input  logic uv_flt,
    output logic lo_off,
    output logic all_off
);
    localparam int LOSS_TICKS = STALL_TICKS / CLK_LOSS_DIV;

    prot_in_t raw;
    prot_in_t syn;
    logic     cmd_prev;
    logic     cmd_rise;
    logic     drive;
    logic     init_done;
    logic     init_active;
    logic     clk_lost;
    logic     other_prot;
    logic     stall_arm;
    logic     stall_done;
    logic     rearm_done;
    logic     stall_latch;

    assign raw = '{lock: lock_det, cmd: cmd_clk, stop: stop_sel,
                   brake: brake_sel, therm: therm_flt, uv: uv_flt};

    mps_sync #(.W($bits(prot_in_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    // Remember the last synchronised command clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_prev <= 1'b0;
        else        cmd_prev <= syn.cmd;
    end

    assign cmd_rise = syn.cmd & ~cmd_prev;
    assign drive    = ~syn.stop & ~syn.brake;

    // Power-up hold: counts INIT_TICKS once after reset.
    mps_tick_timer #(.LIMIT(INIT_TICKS)) u_init (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(1'b1), .clr(1'b0), .done(init_done)
    );
    assign init_active = ~init_done;

    // Clock-loss watchdog: restarted by every command-clock rising edge.
    mps_tick_timer #(.LIMIT(LOSS_TICKS)) u_loss (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(1'b1), .clr(cmd_rise), .done(clk_lost)
    );

    assign other_prot = clk_lost | syn.therm | syn.uv;
    assign stall_arm  = drive & ~syn.lock & ~other_prot & ~init_active
                        & ~stall_latch;

    // Stall window: runs only while lock is absent and nothing else trips.
    mps_tick_timer #(.LIMIT(STALL_TICKS)) u_stall (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(stall_arm), .clr(~stall_arm), .done(stall_done)
    );

    // Re-arm qualification: time spent outside the driving state.
    mps_tick_timer #(.LIMIT(REARM_TICKS)) u_rearm (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(~drive), .clr(drive), .done(rearm_done)
    );

    // Stall latch: set at the window end, cleared on a qualified re-entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                   stall_latch <= 1'b0;
        else if (drive && rearm_done) stall_latch <= 1'b0;
        else if (stall_done)          stall_latch <= 1'b1;
    end

    assign all_off = init_active | syn.uv;
    assign lo_off  = all_off | stall_latch | (drive & (clk_lost | syn.therm));
endmodule

// File: rtl/mps_checker.sv
// Module: property checker for motor_prot_sup, attached with bind.
// It observes the synchronised flags and the protection state that the
// separate timers and the latch produce.
module mps_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic drive,
    input logic lock_s,
    input logic uv_s,
    input logic therm_s,
    input logic clk_lost,
    input logic stall_latch,
    input logic init_active,
    input logic lo_off,
    input logic all_off
);
    // R1: the power-up hold keeps every switch off.
    p_init_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_active |-> (all_off && lo_off));

    // R2: under-voltage forces everything off.
    p_uv_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |-> (all_off && lo_off));

    // R3: a thermal fault in the driving state disables the lower side.
    p_therm_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && therm_s) |-> lo_off);

    // R5: a stall latch is formed only in the driving state without lock.
    p_stall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_latch) |-> ($past(drive) && !$past(lock_s)));

    // R6: a lost clock disables the lower side while driving.
    p_loss_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && clk_lost) |-> lo_off);

    // R7: no stall forms while another protection is active.
    p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_lost || therm_s || uv_s) |=> !$rose(stall_latch));

    // R8: the latch cannot clear while the block stays in the driving state.
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_latch && drive && $past(drive)) |=> stall_latch);

    // R9: without a tick the stall window cannot complete.
    p_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !$rose(stall_latch));
endmodule

bind motor_prot_sup mps_checker u_mps_checker (
    .clk(clk), .rst_n(rst_n), .tick(tick), .drive(drive),
    .lock_s(syn.lock), .uv_s(syn.uv), .therm_s(syn.therm),
    .clk_lost(clk_lost), .stall_latch(stall_latch),
    .init_active(init_active), .lo_off(lo_off), .all_off(all_off)
);

// File: tb/motor_prot_sup_test.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks push expected output pairs into a
// queue, and a monitor compares them at the falling clock edge.
module motor_prot_sup_test;
    localparam int STALL = 340;
    localparam int INIT  = 8;
    localparam int REARM = 10;

    typedef struct {
        string tag;
        logic  lo;
        logic  al;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic lock_det = 1'b1;
    logic cmd_clk = 1'b0;
    logic stop_sel = 1'b0;
    logic brake_sel = 1'b0;
    logic therm_flt = 1'b0;
    logic uv_flt = 1'b0;
    logic clk_en = 1'b1;
    logic lo_off;
    logic all_off;

    exp_t exp_q[$];
    int   tests = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    motor_prot_sup #(.STALL_TICKS(STALL), .INIT_TICKS(INIT),
                     .REARM_TICKS(REARM)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lock_det(lock_det),
        .cmd_clk(cmd_clk), .stop_sel(stop_sel), .brake_sel(brake_sel),
        .therm_flt(therm_flt), .uv_flt(uv_flt),
        .lo_off(lo_off), .all_off(all_off)
    );

    // Command clock: toggles every two cycles while enabled.
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            if (clk_en) cmd_clk = ~cmd_clk;
            else        cmd_clk = 1'b0;
        end
    end

    // Monitor: pop and compare every pending expectation.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            tests++;
            if (lo_off !== e.lo || all_off !== e.al) begin
                fails++;
                $display("FAIL %s: lo_off=%b all_off=%b expected lo_off=%b all_off=%b",
                         e.tag, lo_off, all_off, e.lo, e.al);
            end
        end
    end

    // Wait n rising edges, queue the expectation, and return at the falling edge.
    task automatic wait_chk(input int n, input string tag, input logic lo,
                            input logic al);
        repeat (n) @(posedge clk);
        #1;
        exp_q.push_back('{tag: tag, lo: lo, al: al});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R1: watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        idle(3);
        exp_q.push_back('{tag: "R1 reset state", lo: 1'b1, al: 1'b1});
        idle(1);
        rst_n = 1'b1;
        wait_chk(INIT - 1, "R1 hold before end", 1'b1, 1'b1);
        wait_chk(1, "R1 hold released", 1'b0, 1'b0);
        idle(10);

        // R3 / R10: thermal with two-edge latency.
        therm_flt = 1'b1;
        wait_chk(1, "R10 thermal not yet", 1'b0, 1'b0);
        wait_chk(1, "R3 thermal lo_off", 1'b1, 1'b0);
        therm_flt = 1'b0;
        wait_chk(1, "R10 thermal clear delay", 1'b1, 1'b0);
        wait_chk(1, "R3 thermal released", 1'b0, 1'b0);

        // R2: under-voltage.
        uv_flt = 1'b1;
        wait_chk(2, "R2 uv all_off", 1'b1, 1'b1);
        uv_flt = 1'b0;
        wait_chk(2, "R2 uv released", 1'b0, 1'b0);

        // R4: faults ignored outside the driving state.
        stop_sel = 1'b1;
        idle(3);
        therm_flt = 1'b1;
        wait_chk(4, "R4 thermal in stop", 1'b0, 1'b0);
        therm_flt = 1'b0;
        clk_en = 1'b0;
        wait_chk(30, "R4 clock loss in stop", 1'b0, 1'b0);
        clk_en = 1'b1;
        idle(10);
        stop_sel = 1'b0;
        brake_sel = 1'b1;
        idle(3);
        therm_flt = 1'b1;
        wait_chk(4, "R4 thermal in brake", 1'b0, 1'b0);
        therm_flt = 1'b0;
        idle(3);
        brake_sel = 1'b0;
        wait_chk(4, "R4 back to drive", 1'b0, 1'b0);

        // R6 / R7: clock loss, and stall suppression during it.
        clk_en = 1'b0;
        wait_chk(5, "R6 before loss window", 1'b0, 1'b0);
        wait_chk(15, "R6 clock lost", 1'b1, 1'b0);
        lock_det = 1'b0;
        wait_chk(STALL + 20, "R7 no stall during clock loss", 1'b1, 1'b0);
        clk_en = 1'b1;
        wait_chk(10, "R6 auto release", 1'b0, 1'b0);
        lock_det = 1'b1;
        wait_chk(3, "R7 no latch after clock loss", 1'b0, 1'b0);

        // R7: thermal suppression.
        therm_flt = 1'b1;
        idle(3);
        lock_det = 1'b0;
        wait_chk(STALL + 20, "R7 thermal held", 1'b1, 1'b0);
        therm_flt = 1'b0;
        wait_chk(4, "R7 no latch after thermal", 1'b0, 1'b0);
        lock_det = 1'b1;
        idle(3);

        // R7: under-voltage suppression.
        uv_flt = 1'b1;
        idle(3);
        lock_det = 1'b0;
        wait_chk(STALL + 20, "R7 uv held", 1'b1, 1'b1);
        uv_flt = 1'b0;
        wait_chk(4, "R7 no latch after uv", 1'b0, 1'b0);
        lock_det = 1'b1;
        idle(3);

        // R9: no tick, no stall; tick restored, stall forms.
        tick = 1'b0;
        lock_det = 1'b0;
        wait_chk(STALL + 20, "R9 no tick no stall", 1'b0, 1'b0);
        tick = 1'b1;
        wait_chk(STALL + 20, "R9 stall with ticks", 1'b1, 1'b0);
        lock_det = 1'b1;
        idle(3);

        // R8: long stop clears the latch.
        stop_sel = 1'b1;
        idle(REARM + 2);
        stop_sel = 1'b0;
        wait_chk(6, "R8 long stop clears", 1'b0, 1'b0);

        // R5: exact stall instant, and the latch holds after lock returns.
        lock_det = 1'b0;
        wait_chk(STALL + 2, "R5 one edge before stall", 1'b0, 1'b0);
        wait_chk(1, "R5 stall latched", 1'b1, 1'b0);
        lock_det = 1'b1;
        wait_chk(10, "R5 latch holds with lock", 1'b1, 1'b0);

        // R8: short stop and short brake keep the latch.
        stop_sel = 1'b1;
        idle(REARM / 2);
        stop_sel = 1'b0;
        wait_chk(8, "R8 short stop keeps latch", 1'b1, 1'b0);
        brake_sel = 1'b1;
        idle(REARM / 2);
        brake_sel = 1'b0;
        wait_chk(8, "R8 short brake keeps latch", 1'b1, 1'b0);

        // R8: long brake clears the latch.
        brake_sel = 1'b1;
        idle(REARM + 2);
        brake_sel = 1'b0;
        wait_chk(6, "R8 long brake clears", 1'b0, 1'b0);

        idle(4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule